// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Controller

This block keeps the program counter and the active-lane mask of one warp of parallel threads that share a single instruction stream. Every instruction is issued once for all enabled lanes together. When the issue stage resolves a conditional branch, it presents a per-lane taken vector along with three addresses: the branch target, the fall-through address and the point where the two paths meet again. If every enabled lane goes the same way, the warp simply moves to the chosen address with its mask unchanged. If the enabled lanes disagree, the controller runs the taken side first with only the taken lanes enabled. It then runs the other side with only the remaining lanes. At the meeting point it restores the lanes that were enabled before the branch.

The controller holds the deferred work on a reconvergence stack. A divergent branch pushes two entries. The lower entry holds the meeting address and the mask from before the branch. The upper entry holds the fall-through address and the mask of the not-taken lanes. Both entries use the meeting address as their trigger. Whenever the warp's next address (from a sequential step or a uniform branch) equals the trigger of the top entry, that entry is popped and becomes the current address and mask. A divergence that does not fit on the stack is refused and raises a sticky overflow flag.

Top module: `warp_reconverge_ctrl`

## Requirements
- R1: After reset, `warp_pc` equals the parameter RESET_PC, every bit of `warp_mask` is 1 (bit i is lane i) and `ovf` is 0; the stack is empty.
- R2: A step (`step_valid`=1, `br_valid`=0) whose `step_pc` differs from the top entry's trigger (or with an empty stack) sets `warp_pc` to `step_pc` in the next cycle and leaves `warp_mask` unchanged.
- R3: A branch is uniform when `br_taken & warp_mask` equals `warp_mask` (next pc `br_target`) or is zero (next pc `br_fall`). The mask is kept, and the bits of `br_taken` for disabled lanes have no effect on the result.
- R4: A divergent branch with at least two free stack slots sets `warp_pc` to `br_target` and `warp_mask` to `br_taken & warp_mask`. It pushes {pc=`br_join`, mask=old mask, trigger=`br_join`} and then {pc=`br_fall`, mask=`warp_mask & ~br_taken`, trigger=`br_join`}.
- R5: When the next pc chosen by a step or a uniform branch equals the top entry's trigger, the top entry is removed and its pc and mask become `warp_pc` and `warp_mask`. At most one entry is removed per cycle.
- R6: After a divergence, the first arrival at the meeting address moves the warp to the fall-through address with the not-taken lanes only. The second arrival moves it to the meeting address with the pre-branch mask.
- R7: The stack holds DEPTH entries (default 8). A divergent branch that finds fewer than two free slots sets `ovf`, and `warp_pc`, `warp_mask` and the stack stay unchanged.
- R8: `ovf` stays at 1 until reset, whatever the later events.
- R9: When `br_valid` and `step_valid` are both 1 in a cycle, only the branch is acted on and `step_pc` has no effect.
- R10: In a cycle with neither `br_valid` nor `step_valid`, `warp_pc` and `warp_mask` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | Warp moves to `step_pc` (non-branch progress) |
| step_pc | input | PC_W | Next sequential address of the warp |
| br_valid | input | 1 | A conditional branch is resolved this cycle |
| br_taken | input | LANES | Per-lane branch outcome, bit i is lane i |
| br_target | input | PC_W | Address of the taken path |
| br_fall | input | PC_W | Address of the not-taken path |
| br_join | input | PC_W | Address where both paths meet again |
| warp_pc | output | PC_W | Current address sent to the issue stage |
| warp_mask | output | LANES | Current enabled lanes, bit i is lane i |
| ovf | output | 1 | Sticky flag: a divergence did not fit on the stack |

## Verification
The assertions assume a well-formed program: each meeting address lies past both sides of its branch, and `warp_mask` only leaves the all-ones state through divergence, so the mask they watch is never empty. They also assume that the inputs are stable around the sampling edge. The bench drives every input two nanoseconds after a rising edge. Its random branches draw taken vectors from the current mask, and its meeting addresses from a small pool that is reused, so pops, nested splits and overflow all occur. Because disabled lanes are masked out, random taken bits on those lanes stay legal stimulus.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

   // Classification of what the warp does in one cycle.
   typedef enum logic [2:0] {
      EV_IDLE    = 3'd0,
      EV_STEP    = 3'd1,
      EV_UNIFORM = 3'd2,
      EV_SPLIT   = 3'd3,
      EV_REFUSE  = 3'd4
   } wrc_event_e;

   localparam int unsigned WRC_MIN_DEPTH = 2;

endpackage

// File: rtl/wrc_split.sv
// Per-lane split of the branch outcome into the enabled-taken and
// enabled-not-taken sets, plus the two uniformity tests.
module wrc_split #(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0] act_mask,
   input  logic [LANES-1:0] taken,
   output logic [LANES-1:0] take_set,
   output logic [LANES-1:0] skip_set,
   output logic             all_take,
   output logic             none_take
);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign take_set[ln] = act_mask[ln] &  taken[ln];
      assign skip_set[ln] = act_mask[ln] & ~taken[ln];
   end

   assign none_take = (take_set == '0);
   assign all_take  = (skip_set == '0);

endmodule

// File: rtl/wrc_stack.sv
// Reconvergence stack: pushes two entries at once, pops one.
module wrc_stack #(
   parameter int W     = 96,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push2,
   input  logic [W-1:0]  d_lo,
   input  logic [W-1:0]  d_hi,
   input  logic          pop,
   output logic [W-1:0]  top,
   output logic [CW-1:0] cnt,
   output logic          room2
);

   logic [W-1:0]  slot [DEPTH];
   logic [CW-1:0] cnt_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push2 && (cnt_q == CW'(i)))
            slot[i] <= d_lo;
         else if (push2 && ((cnt_q + CW'(1)) == CW'(i)))
            slot[i] <= d_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (push2)
         cnt_q <= cnt_q + CW'(2);
      else if (pop && (cnt_q != '0))
         cnt_q <= cnt_q - CW'(1);
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if ((CW'(i) + CW'(1)) == cnt_q)
            top = slot[i];
      end
   end

   assign cnt   = cnt_q;
   assign room2 = (int'(cnt_q) <= DEPTH - 2);

endmodule

// File: rtl/warp_reconverge_ctrl.sv
module warp_reconverge_ctrl #(
   parameter int          LANES    = 32,
   parameter int          PC_W     = 32,
   parameter int          DEPTH    = 8,
   parameter logic [31:0] RESET_PC = 32'h0,
   localparam int         EW       = 2 * PC_W + LANES,
   localparam int         CW       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_valid,
   input  logic [PC_W-1:0]  step_pc,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_taken,
   input  logic [PC_W-1:0]  br_target,
   input  logic [PC_W-1:0]  br_fall,
   input  logic [PC_W-1:0]  br_join,
   output logic [PC_W-1:0]  warp_pc,
   output logic [LANES-1:0] warp_mask,
   output logic             ovf
);
   import wrc_pkg::*;

   if (LANES < 1) begin : g_bad_lanes
      $error("warp_reconverge_ctrl: LANES must be at least 1");
   end
   if (DEPTH < int'(WRC_MIN_DEPTH)) begin : g_bad_depth
      $error("warp_reconverge_ctrl: DEPTH must hold one divergence (2 entries)");
   end
   if (PC_W < 1 || PC_W > 32) begin : g_bad_pcw
      $error("warp_reconverge_ctrl: PC_W must lie in 1..32");
   end

   // Entry layout: {resume pc, mask, trigger pc}
   logic [PC_W-1:0]  pc_q;
   logic [LANES-1:0] mask_q;
   logic             ovf_q;

   logic [LANES-1:0] take_set, skip_set;
   logic             all_take, none_take;

   logic [EW-1:0]    top_w;
   logic [CW-1:0]    cnt_w;
   logic             room2_w;
   logic [PC_W-1:0]  top_pc, top_rpc;
   logic [LANES-1:0] top_mask;

   wrc_event_e       ev;
   logic             push2_w, pop_w, ovf_set;
   logic [PC_W-1:0]  cand_pc, nxt_pc;
   logic [LANES-1:0] nxt_mask;
   logic [EW-1:0]    ent_lo, ent_hi;

   wrc_split #(.LANES(LANES)) u_split (
      .act_mask (mask_q),
      .taken    (br_taken),
      .take_set (take_set),
      .skip_set (skip_set),
      .all_take (all_take),
      .none_take(none_take)
   );

   wrc_stack #(.W(EW), .DEPTH(DEPTH)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push2 (push2_w),
      .d_lo  (ent_lo),
      .d_hi  (ent_hi),
      .pop   (pop_w),
      .top   (top_w),
      .cnt   (cnt_w),
      .room2 (room2_w)
   );

   assign top_pc   = top_w[EW-1 -: PC_W];
   assign top_mask = top_w[PC_W +: LANES];
   assign top_rpc  = top_w[PC_W-1:0];

   assign ent_lo = {br_join, mask_q,   br_join};
   assign ent_hi = {br_fall, skip_set, br_join};

   // Event classification: a branch outranks a step.
   always_comb begin
      ev = EV_IDLE;
      if (br_valid) begin
         if (all_take || none_take) ev = EV_UNIFORM;
         else if (room2_w)          ev = EV_SPLIT;
         else                       ev = EV_REFUSE;
      end else if (step_valid) begin
         ev = EV_STEP;
      end
   end

   // Next-state selection with a single trigger compare on the new pc.
   always_comb begin
      push2_w  = 1'b0;
      pop_w    = 1'b0;
      ovf_set  = 1'b0;
      nxt_pc   = pc_q;
      nxt_mask = mask_q;
      cand_pc  = step_pc;
      if (ev == EV_UNIFORM)
         cand_pc = all_take ? br_target : br_fall;
      case (ev)
         EV_STEP, EV_UNIFORM: begin
            nxt_pc = cand_pc;
            if ((cnt_w != '0) && (cand_pc == top_rpc)) begin
               pop_w    = 1'b1;
               nxt_pc   = top_pc;
               nxt_mask = top_mask;
            end
         end
         EV_SPLIT: begin
            push2_w  = 1'b1;
            nxt_pc   = br_target;
            nxt_mask = take_set;
         end
         EV_REFUSE: ovf_set = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC[PC_W-1:0];
         mask_q <= '1;
         ovf_q  <= 1'b0;
      end else begin
         pc_q   <= nxt_pc;
         mask_q <= nxt_mask;
         if (ovf_set) ovf_q <= 1'b1;
      end
   end

   assign warp_pc   = pc_q;
   assign warp_mask = mask_q;
   assign ovf       = ovf_q;

endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
   parameter int  LANES = 32,
   parameter int  PC_W  = 32,
   parameter int  DEPTH = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_valid,
   input logic             br_valid,
   input logic [LANES-1:0] br_taken,
   input logic [PC_W-1:0]  br_target,
   input logic [PC_W-1:0]  warp_pc,
   input logic [LANES-1:0] warp_mask,
   input logic             ovf,
   input logic             pop,
   input logic             room2,
   input logic [CW-1:0]    cnt
);

   logic [LANES-1:0] t_eff;
   logic             split_now, uni_now;
   assign t_eff     = br_taken & warp_mask;
   assign split_now = br_valid && (t_eff != '0) && (t_eff != warp_mask);
   assign uni_now   = br_valid && !split_now;

   // R8: the overflow flag never clears without reset
   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R4: a split that fits enables exactly the taken lanes at the target
   assert_split_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (split_now && room2) |=> (warp_mask == $past(t_eff)) && (warp_pc == $past(br_target)));

   // R7: a split without room leaves pc and mask and raises the flag
   assert_refuse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (split_now && !room2) |=> ovf && $stable(warp_pc) && $stable(warp_mask));

   // R3: a uniform branch with no pop keeps the mask
   assert_uniform_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (uni_now && !pop) |=> $stable(warp_mask));

   // R10: no event, no change
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !step_valid) |=> $stable(warp_pc) && $stable(warp_mask));

   // R7: stack occupancy never exceeds its depth
   assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= DEPTH);

   // R5: a pop shrinks the stack by one
   assert_pop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (cnt == $past(cnt) - CW'(1)));

endmodule

bind warp_reconverge_ctrl wrc_checker #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_valid(step_valid),
   .br_valid  (br_valid),
   .br_taken  (br_taken),
   .br_target (br_target),
   .warp_pc   (warp_pc),
   .warp_mask (warp_mask),
   .ovf       (ovf),
   .pop       (pop_w),
   .room2     (room2_w),
   .cnt       (cnt_w)
);

// File: tb/sim_warp_reconverge_ctrl.sv
`timescale 1ns/1ps
module sim_warp_reconverge_ctrl;
   localparam int L = 32;
   localparam int P = 32;
   localparam int D = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         step_valid = 1'b0, br_valid = 1'b0;
   logic [P-1:0] step_pc = '0, br_target = '0, br_fall = '0, br_join = '0;
   logic [L-1:0] br_taken = '0;
   logic [P-1:0] warp_pc;
   logic [L-1:0] warp_mask;
   logic         ovf;

   int total = 0, fails = 0;

   // Reference state
   logic [P-1:0] e_pc;
   logic [L-1:0] e_mask;
   logic         e_ovf;
   logic [P-1:0] s_pc   [D];
   logic [L-1:0] s_mask [D];
   logic [P-1:0] s_rpc  [D];
   int           s_cnt;

   always #4 clk = ~clk;

   warp_reconverge_ctrl #(.LANES(L), .PC_W(P), .DEPTH(D), .RESET_PC(32'h0)) u0 (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_pc(step_pc),
      .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
      .br_fall(br_fall), .br_join(br_join),
      .warp_pc(warp_pc), .warp_mask(warp_mask), .ovf(ovf)
   );

   task automatic summary();
      $display("  %0d/%0d checks passed", total - fails, total);
   endtask

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cmp(input string tag);
      check({tag, " pc"},   64'(warp_pc),   64'(e_pc));
      check({tag, " mask"}, 64'(warp_mask), 64'(e_mask));
      check({tag, " ovf"},  64'(ovf),       64'(e_ovf));
   endtask

   task automatic mdl_reset();
      e_pc = '0; e_mask = '1; e_ovf = 1'b0; s_cnt = 0;
   endtask

   // Requirement-level model of one cycle.
   task automatic mdl(input logic bv, input logic [L-1:0] bt, input logic [P-1:0] tg,
                      input logic [P-1:0] fl, input logic [P-1:0] jn,
                      input logic sv, input logic [P-1:0] sp);
      logic         chk;
      logic [P-1:0] c;
      logic [L-1:0] ta;
      chk = 1'b0; c = sp; ta = bt & e_mask;
      if (bv) begin
         if (ta == e_mask)   begin chk = 1'b1; c = tg; end
         else if (ta == '0)  begin chk = 1'b1; c = fl; end
         else if (s_cnt <= D - 2) begin
            s_pc[s_cnt] = jn; s_mask[s_cnt] = e_mask; s_rpc[s_cnt] = jn;
            s_pc[s_cnt+1] = fl; s_mask[s_cnt+1] = e_mask & ~bt; s_rpc[s_cnt+1] = jn;
            s_cnt += 2; e_pc = tg; e_mask = ta;
         end else e_ovf = 1'b1;
      end else if (sv) chk = 1'b1;
      if (chk) begin
         e_pc = c;
         if (s_cnt > 0 && c == s_rpc[s_cnt-1]) begin
            s_cnt--; e_pc = s_pc[s_cnt]; e_mask = s_mask[s_cnt];
         end
      end
   endtask

   task automatic go(input logic bv, input logic [L-1:0] bt, input logic [P-1:0] tg,
                     input logic [P-1:0] fl, input logic [P-1:0] jn,
                     input logic sv, input logic [P-1:0] sp);
      br_valid = bv; br_taken = bt; br_target = tg; br_fall = fl; br_join = jn;
      step_valid = sv; step_pc = sp;
      mdl(bv, bt, tg, fl, jn, sv, sp);
      @(posedge clk); #2;
   endtask

   task automatic step(input logic [P-1:0] sp);
      go(1'b0, '0, '0, '0, '0, 1'b1, sp);
   endtask

   task automatic idle();
      go(1'b0, '0, '0, '0, '0, 1'b0, '0);
   endtask

   task automatic do_reset();
      br_valid = 1'b0; step_valid = 1'b0;
      rst_n = 1'b0; mdl_reset();
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      do_reset();
      cmp("R1 reset");
      check("R1 pc value", 64'(warp_pc), 64'h0);
      check("R1 mask value", 64'(warp_mask), 64'hFFFF_FFFF);

      step(32'h10);                         cmp("R2 step");
      check("R2 pc value", 64'(warp_pc), 64'h10);
      go(1'b1, '1, 32'h40, 32'h14, 32'h80, 1'b0, '0); cmp("R3 all taken");
      go(1'b1, '0, 32'h44, 32'h48, 32'h80, 1'b0, '0); cmp("R3 none taken");
      check("R3 fall value", 64'(warp_pc), 64'h48);

      go(1'b1, 32'h0000_FFFF, 32'h100, 32'h200, 32'h300, 1'b0, '0);
      cmp("R4 split");
      check("R4 mask value", 64'(warp_mask), 64'h0000_FFFF);
      check("R4 pc value", 64'(warp_pc), 64'h100);

      go(1'b1, 32'hABCD_FFFF, 32'h120, 32'h124, 32'h0, 1'b0, '0); cmp("R3 inactive bits set");
      check("R3 ignore pc", 64'(warp_pc), 64'h120);
      go(1'b1, 32'h5A5A_0000, 32'h130, 32'h134, 32'h0, 1'b0, '0); cmp("R3 inactive only");
      check("R3 ignore mask", 64'(warp_mask), 64'h0000_FFFF);

      step(32'h300);                        cmp("R6 first arrival");
      check("R6 fall pc", 64'(warp_pc), 64'h200);
      check("R6 fall mask", 64'(warp_mask), 64'hFFFF_0000);

      go(1'b1, 32'hFFFF_0000, 32'h250, 32'h254, 32'h0, 1'b1, 32'h300);
      cmp("R9 branch wins");
      check("R9 pc value", 64'(warp_pc), 64'h250);

      idle(); idle(); idle();               cmp("R10 hold");

      go(1'b1, 32'hFFFF_0000, 32'h300, 32'h0, 32'h0, 1'b0, '0);
      cmp("R5 pop on uniform branch");
      check("R6 rejoin mask", 64'(warp_mask), 64'hFFFF_FFFF);
      check("R6 rejoin pc", 64'(warp_pc), 64'h300);

      // Nested splits fill the stack, the fifth is refused.
      go(1'b1, 32'h0000_FFFF, 32'h1000, 32'h1100, 32'h1200, 1'b0, '0);
      go(1'b1, 32'h0000_00FF, 32'h2000, 32'h2100, 32'h2200, 1'b0, '0);
      go(1'b1, 32'h0000_000F, 32'h3000, 32'h3100, 32'h3200, 1'b0, '0);
      go(1'b1, 32'h0000_0003, 32'h4000, 32'h4100, 32'h4200, 1'b0, '0);
      cmp("R7 full stack");
      go(1'b1, 32'h0000_0001, 32'h9000, 32'h9100, 32'h9200, 1'b0, '0);
      cmp("R7 refused split");
      check("R7 ovf raised", 64'(ovf), 64'h1);
      check("R7 pc kept", 64'(warp_pc), 64'h4000);
      step(32'h1234);                       cmp("R8 sticky");
      foreach (s_rpc[i]) begin end
      step(32'h4200); cmp("R5 unwind a");
      step(32'h4200); cmp("R5 unwind b");
      step(32'h3200); step(32'h3200);       cmp("R5 unwind c");
      step(32'h2200); step(32'h2200);
      step(32'h1200); step(32'h1200);       cmp("R6 outer rejoin");
      check("R6 full mask", 64'(warp_mask), 64'hFFFF_FFFF);
      check("R8 still set", 64'(ovf), 64'h1);

      do_reset();
      cmp("R1 reset clears ovf");

      // Random phases
      for (int ph = 0; ph < 3; ph++) begin
         for (int n = 0; n < 3000; n++) begin
            int r;
            logic [L-1:0] bt;
            logic [P-1:0] jn, sp;
            r  = int'($urandom % 10);
            jn = P'(32'h800 + ($urandom % 6) * 32'h10);
            case ($urandom % 4)
               0: bt = L'($urandom);
               1: bt = e_mask & L'($urandom);
               2: bt = '1;
               default: bt = '0;
            endcase
            if (s_cnt > 0 && ($urandom % 2) == 1) sp = s_rpc[s_cnt-1];
            else sp = P'(($urandom % 64) * 4);
            if (r < 4)
               go(1'b1, bt, P'(($urandom % 64) * 4), P'(($urandom % 64) * 4), jn, 1'b0, sp);
            else if (r < 8)
               go(1'b0, bt, '0, '0, jn, 1'b1, sp);
            else if (r == 8)
               go(1'b1, bt, sp, P'(($urandom % 64) * 4), jn, 1'b1, sp);
            else
               idle();
            cmp("R5 random model");
         end
         do_reset();
         cmp("R1 random reset");
      end

      summary();
      $finish;
   end
endmodule